// File: doc/BRIEF.md
# VT/TU Pointer Byte Generator

This block produces the four V-bytes (V1, V2, V3, V4) that head each superframe of a VT1.5/TU-11 or VT2/TU-12 tributary. It also supplies the first payload byte after V3 when that byte must be a stuff byte. A slot strobe with a slot code asks for one byte at a time. The block answers in the same cycle with the byte and two flags. One flag tells the payload path that V3 carries data (negative justification). The other tells it that the byte following V3 is a stuff byte (positive justification).

Two pointer modes exist. For asynchronous and bit-synchronous mapping the pointer is a constant that depends on the tributary size. For byte-synchronous mapping the pointer is a register that moves: justification requests step it by one, and new-data requests load it from a supplied value. An AIS-V request overrides both modes and fills every V-byte with ones. Requests are pulses. They are held pending and acted on at the next superframe start, which is the V1 strobe.

Top module: `vt_ptr_gen`

## Requirements
- R1: With byte_sync_i low and AIS-V off, the pointer sent is 78 for VT1.5 (vt2_i low) and 105 for VT2 (vt2_i high). The new-data flag is 0110, and increment, decrement and new-data requests change nothing.
- R2: The V1/V2 word is {new-data flag[3:0], size[1:0], pointer[9:0]}, MSB first, with V1 as the upper byte. The size field is 11 for VT1.5 and 10 for VT2.
- R3: While ais_i is high, the V1, V2, V3 and V4 slots return 0xFF in every mode. The slot after V3 returns 0x00 and both flags stay low.
- R4: With byte_sync_i low and AIS-V off, V3 and V4 return oh_dflt_i, the slot after V3 returns 0x00, and both flags stay low.
- R5: In byte-synchronous mode, a new-data request loads ptr_req_i into the pointer. It is sent with flag 1001 in the next superframe and with flag 0110 afterwards. A requested value above the size's maximum (103 for VT1.5, 139 for VT2) is ignored.
- R6: An accepted increment sends the current pointer with its I bits inverted (mask 0x2AA). V3 and the slot after V3 return stuff_dflt_i, and p3_stuff_o is high in that slot. The next superframe sends pointer+1.
- R7: An accepted decrement sends the current pointer with its D bits inverted (mask 0x155). V3 returns 0x00 with v3_data_o high. The next superframe sends pointer-1.
- R8: An increment at the size's maximum becomes a new-data event (flag 1001) with pointer 0. A decrement at 0 becomes a new-data event with the size's maximum. Neither inverts any bit.
- R9: After any pointer change, increment and decrement requests met at the next three superframe starts are discarded. A request met at the fourth is accepted.
- R10: Requests are acted on at the first V1 strobe after they are raised. A request raised in the V1 strobe cycle itself applies to the following superframe. When requests coincide, new-data wins over increment, and increment wins over decrement.
- R11: In byte-synchronous mode, V4 returns oh_dflt_i. In superframes with no justification, V3 also returns oh_dflt_i.
- R12: With v_stb_i low, or with a slot code above 4, vbyte_o is 0x00 and both flags are low. Slot codes are V1=0, V2=1, V3=2, V4=3, and byte after V3=4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| vt2_i | input | 1 | 1 selects VT2/TU-12, 0 selects VT1.5/TU-11 |
| byte_sync_i | input | 1 | 1 selects the floating pointer, 0 the fixed pointer |
| ais_i | input | 1 | AIS-V request |
| inc_req_i | input | 1 | Increment request pulse |
| dec_req_i | input | 1 | Decrement request pulse |
| ndf_req_i | input | 1 | New-data request pulse, loads ptr_req_i |
| ptr_req_i | input | 10 | Pointer value for a new-data request |
| oh_dflt_i | input | 8 | Overhead default byte |
| stuff_dflt_i | input | 8 | Fixed-stuff default byte |
| v_stb_i | input | 1 | Slot strobe |
| v_sel_i | input | 3 | Slot code: 0 V1, 1 V2, 2 V3, 3 V4, 4 byte after V3 |
| vbyte_o | output | 8 | Byte for the strobed slot |
| v3_data_o | output | 1 | V3 slot carries payload data |
| p3_stuff_o | output | 1 | Byte after V3 is a stuff byte |

## Verification
The hardest situations to reach from the ports are the wrap cases and the guard window. To reach a wrap, the pointer must first sit exactly at a boundary, and then the hold period has to run out before the justification is accepted. The bench gets there by loading 139, 103 or 0 through a new-data request and letting three empty superframes pass. It then issues the request and checks the new-data word that replaces the inversion. The guard window is probed from the other side. A request is placed in the first superframe after a change and must be discarded, and a second request placed exactly at the fourth superframe must be accepted.

// File: rtl/vt_ptr_pkg.sv
package vt_ptr_pkg;
  localparam int PTR_W = 10;

  typedef enum logic [2:0] {
    SL_V1 = 3'd0,
    SL_V2 = 3'd1,
    SL_V3 = 3'd2,
    SL_V4 = 3'd3,
    SL_P3 = 3'd4
  } slot_e;

  typedef enum logic [1:0] {
    ACT_NONE = 2'd0,
    ACT_INC  = 2'd1,
    ACT_DEC  = 2'd2,
    ACT_NDF  = 2'd3
  } act_e;

  localparam logic [3:0]       NDF_NORM = 4'b0110;
  localparam logic [3:0]       NDF_SET  = 4'b1001;
  localparam logic [1:0]       SS_VT15  = 2'b11;
  localparam logic [1:0]       SS_VT2   = 2'b10;
  localparam logic [PTR_W-1:0] I_MASK   = 10'h2AA;
  localparam logic [PTR_W-1:0] D_MASK   = 10'h155;
endpackage

// File: rtl/vt_ptr_ctrl.sv
module vt_ptr_ctrl
  import vt_ptr_pkg::*;
#(
  parameter int unsigned VT15_MAX = 103,
  parameter int unsigned VT2_MAX  = 139,
  parameter int unsigned HOLD_SF  = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             vt2_i,
  input  logic             byte_sync_i,
  input  logic             ais_i,
  input  logic             inc_req_i,
  input  logic             dec_req_i,
  input  logic             ndf_req_i,
  input  logic [PTR_W-1:0] ptr_req_i,
  input  logic             sf_start_i,
  output act_e             act_o,
  output logic [PTR_W-1:0] ptr_o
);
  localparam int unsigned      HW        = $clog2(HOLD_SF + 1);
  localparam logic [PTR_W-1:0] MAX15     = PTR_W'(VT15_MAX);
  localparam logic [PTR_W-1:0] MAX2      = PTR_W'(VT2_MAX);
  localparam logic [HW-1:0]    HOLD_INIT = HW'(HOLD_SF);

  logic [PTR_W-1:0] ptr_q, tx_q, ndf_val_q;
  logic [PTR_W-1:0] max_w, tx_d, nxt_d;
  logic             pend_inc_q, pend_dec_q, pend_ndf_q;
  logic [HW-1:0]    hold_q, hold_d;
  act_e             act_q, act_d;

  // decision taken at superframe start
  always_comb begin
    max_w = vt2_i ? MAX2 : MAX15;
    act_d = ACT_NONE;
    tx_d  = ptr_q;
    nxt_d = ptr_q;
    if (byte_sync_i && !ais_i) begin
      if (pend_ndf_q && (ndf_val_q <= max_w)) begin
        act_d = ACT_NDF;
        tx_d  = ndf_val_q;
        nxt_d = ndf_val_q;
      end else if (hold_q == '0) begin
        if (pend_inc_q) begin
          if (ptr_q >= max_w) begin
            act_d = ACT_NDF;
            tx_d  = '0;
            nxt_d = '0;
          end else begin
            act_d = ACT_INC;
            nxt_d = ptr_q + 1'b1;
          end
        end else if (pend_dec_q) begin
          if (ptr_q == '0) begin
            act_d = ACT_NDF;
            tx_d  = max_w;
            nxt_d = max_w;
          end else begin
            act_d = ACT_DEC;
            nxt_d = ptr_q - 1'b1;
          end
        end
      end
    end
    hold_d = hold_q;
    if (act_d != ACT_NONE)  hold_d = HOLD_INIT;
    else if (hold_q != '0)  hold_d = hold_q - 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q      <= '0;
      tx_q       <= '0;
      ndf_val_q  <= '0;
      pend_inc_q <= 1'b0;
      pend_dec_q <= 1'b0;
      pend_ndf_q <= 1'b0;
      hold_q     <= '0;
      act_q      <= ACT_NONE;
    end else begin
      pend_inc_q <= (pend_inc_q && !sf_start_i) || inc_req_i;
      pend_dec_q <= (pend_dec_q && !sf_start_i) || dec_req_i;
      pend_ndf_q <= (pend_ndf_q && !sf_start_i) || ndf_req_i;
      if (ndf_req_i) ndf_val_q <= ptr_req_i;
      if (sf_start_i) begin
        ptr_q  <= nxt_d;
        tx_q   <= tx_d;
        act_q  <= act_d;
        hold_q <= hold_d;
      end
    end
  end

  assign act_o = sf_start_i ? act_d : act_q;
  assign ptr_o = sf_start_i ? tx_d  : tx_q;
endmodule

// File: rtl/vt_ptr_fmt.sv
module vt_ptr_fmt
  import vt_ptr_pkg::*;
#(
  parameter int unsigned VT15_FIX = 78,
  parameter int unsigned VT2_FIX  = 105
) (
  input  logic             vt2_i,
  input  logic             byte_sync_i,
  input  logic             ais_i,
  input  act_e             act_i,
  input  logic [PTR_W-1:0] ptr_i,
  input  logic             v_stb_i,
  input  logic [2:0]       v_sel_i,
  input  logic [7:0]       oh_dflt_i,
  input  logic [7:0]       stuff_dflt_i,
  output logic [7:0]       vbyte_o,
  output logic             v3_data_o,
  output logic             p3_stuff_o
);
  localparam logic [PTR_W-1:0] FIX15 = PTR_W'(VT15_FIX);
  localparam logic [PTR_W-1:0] FIX2  = PTR_W'(VT2_FIX);

  logic             is_inc, is_dec, is_ndf;
  logic [PTR_W-1:0] ptr_w, pw;
  logic [15:0]      word;

  always_comb begin
    is_inc = byte_sync_i && !ais_i && (act_i == ACT_INC);
    is_dec = byte_sync_i && !ais_i && (act_i == ACT_DEC);
    is_ndf = byte_sync_i && !ais_i && (act_i == ACT_NDF);
    ptr_w  = byte_sync_i ? ptr_i : (vt2_i ? FIX2 : FIX15);
    pw     = ptr_w ^ (is_inc ? I_MASK : '0) ^ (is_dec ? D_MASK : '0);
    word   = {(is_ndf ? NDF_SET : NDF_NORM), (vt2_i ? SS_VT2 : SS_VT15), pw};

    vbyte_o    = 8'h00;
    v3_data_o  = 1'b0;
    p3_stuff_o = 1'b0;
    if (v_stb_i) begin
      case (v_sel_i)
        SL_V1: vbyte_o = ais_i ? 8'hFF : word[15:8];
        SL_V2: vbyte_o = ais_i ? 8'hFF : word[7:0];
        SL_V3: begin
          if (ais_i)       vbyte_o = 8'hFF;
          else if (is_inc) vbyte_o = stuff_dflt_i;
          else if (is_dec) vbyte_o = 8'h00;
          else             vbyte_o = oh_dflt_i;
          v3_data_o = is_dec;
        end
        SL_V4: vbyte_o = ais_i ? 8'hFF : oh_dflt_i;
        SL_P3: begin
          vbyte_o    = is_inc ? stuff_dflt_i : 8'h00;
          p3_stuff_o = is_inc;
        end
        default: vbyte_o = 8'h00;
      endcase
    end
  end
endmodule

// File: rtl/vt_ptr_gen.sv
module vt_ptr_gen
  import vt_ptr_pkg::*;
#(
  parameter int unsigned VT15_FIX = 78,
  parameter int unsigned VT2_FIX  = 105,
  parameter int unsigned VT15_MAX = 103,
  parameter int unsigned VT2_MAX  = 139,
  parameter int unsigned HOLD_SF  = 3
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       vt2_i,
  input  logic       byte_sync_i,
  input  logic       ais_i,
  input  logic       inc_req_i,
  input  logic       dec_req_i,
  input  logic       ndf_req_i,
  input  logic [9:0] ptr_req_i,
  input  logic [7:0] oh_dflt_i,
  input  logic [7:0] stuff_dflt_i,
  input  logic       v_stb_i,
  input  logic [2:0] v_sel_i,
  output logic [7:0] vbyte_o,
  output logic       v3_data_o,
  output logic       p3_stuff_o
);
  logic             sf_start_w;
  act_e             act_w;
  logic [PTR_W-1:0] ptr_w;

  assign sf_start_w = v_stb_i && (v_sel_i == SL_V1);

  vt_ptr_ctrl #(
    .VT15_MAX(VT15_MAX), .VT2_MAX(VT2_MAX), .HOLD_SF(HOLD_SF)
  ) ctrl_i (
    .clk_i, .rst_ni, .vt2_i, .byte_sync_i, .ais_i,
    .inc_req_i, .dec_req_i, .ndf_req_i, .ptr_req_i,
    .sf_start_i(sf_start_w),
    .act_o     (act_w),
    .ptr_o     (ptr_w)
  );

  vt_ptr_fmt #(
    .VT15_FIX(VT15_FIX), .VT2_FIX(VT2_FIX)
  ) fmt_i (
    .vt2_i, .byte_sync_i, .ais_i,
    .act_i(act_w),
    .ptr_i(ptr_w),
    .v_stb_i, .v_sel_i, .oh_dflt_i, .stuff_dflt_i,
    .vbyte_o, .v3_data_o, .p3_stuff_o
  );
endmodule

// File: rtl/vt_ptr_chk.sv
module vt_ptr_chk
  import vt_ptr_pkg::*;
#(
  parameter int unsigned VT15_FIX = 78,
  parameter int unsigned VT2_FIX  = 105,
  parameter int unsigned HOLD_SF  = 3
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       vt2_i,
  input logic       byte_sync_i,
  input logic       ais_i,
  input logic       v_stb_i,
  input logic [2:0] v_sel_i,
  input logic [7:0] oh_dflt_i,
  input logic [7:0] stuff_dflt_i,
  input logic [7:0] vbyte_o,
  input logic       v3_data_o,
  input logic       p3_stuff_o,
  input logic       sf_start_w,
  input act_e       act_w
);
  localparam int unsigned HW = $clog2(HOLD_SF + 1);
  localparam logic [15:0] W15 = {NDF_NORM, SS_VT15, 10'(VT15_FIX)};
  localparam logic [15:0] W2  = {NDF_NORM, SS_VT2,  10'(VT2_FIX)};

  logic [HW-1:0] sf_since_q;
  logic          in_v1, in_v2, norm;

  assign in_v1 = v_stb_i && (v_sel_i == SL_V1);
  assign in_v2 = v_stb_i && (v_sel_i == SL_V2);
  assign norm  = !byte_sync_i && !ais_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sf_since_q <= HW'(HOLD_SF);
    else if (sf_start_w) begin
      if (act_w != ACT_NONE)              sf_since_q <= '0;
      else if (sf_since_q < HW'(HOLD_SF)) sf_since_q <= sf_since_q + 1'b1;
    end
  end

  AST_FIXED_V1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_v1 && norm |-> vbyte_o == (vt2_i ? W2[15:8] : W15[15:8])); // R1
  AST_FIXED_V2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_v2 && norm |-> vbyte_o == (vt2_i ? W2[7:0] : W15[7:0])); // R1
  AST_SIZE_FIELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_v1 && !ais_i |-> vbyte_o[3:2] == (vt2_i ? 2'b10 : 2'b11)); // R2
  AST_AIS_ONES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    v_stb_i && ais_i && (v_sel_i <= 3'd3) |-> vbyte_o == 8'hFF); // R3
  AST_FIXED_V3V4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    v_stb_i && norm && (v_sel_i == SL_V3 || v_sel_i == SL_V4) |-> vbyte_o == oh_dflt_i); // R4
  AST_P3_STUFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    p3_stuff_o |-> byte_sync_i && !ais_i && vbyte_o == stuff_dflt_i); // R6
  AST_DEC_V3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    v3_data_o |-> byte_sync_i && !ais_i && v_sel_i == SL_V3 && vbyte_o == 8'h00); // R7
  AST_HOLD_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sf_start_w && (act_w == ACT_INC || act_w == ACT_DEC) |-> sf_since_q == HW'(HOLD_SF)); // R9
  AST_IDLE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !v_stb_i |-> vbyte_o == 8'h00 && !v3_data_o && !p3_stuff_o); // R12
endmodule

bind vt_ptr_gen vt_ptr_chk #(
  .VT15_FIX(VT15_FIX), .VT2_FIX(VT2_FIX), .HOLD_SF(HOLD_SF)
) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .vt2_i(vt2_i), .byte_sync_i(byte_sync_i),
  .ais_i(ais_i), .v_stb_i(v_stb_i), .v_sel_i(v_sel_i), .oh_dflt_i(oh_dflt_i),
  .stuff_dflt_i(stuff_dflt_i), .vbyte_o(vbyte_o), .v3_data_o(v3_data_o),
  .p3_stuff_o(p3_stuff_o), .sf_start_w(sf_start_w), .act_w(act_w)
);

// File: tb/vt_ptr_gen_tb.sv
module vt_ptr_gen_tb_top;
  localparam int CLK_P = 10;
  localparam logic [7:0] OH = 8'h5A;
  localparam logic [7:0] ST = 8'hC3;
  localparam logic [9:0] IM = 10'h2AA;
  localparam logic [9:0] DM = 10'h155;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       vt2 = 1'b0, bs = 1'b0, ais = 1'b0;
  logic       inc_r = 1'b0, dec_r = 1'b0, ndf_r = 1'b0;
  logic [9:0] preq = '0;
  logic       stb = 1'b0;
  logic [2:0] sel = '0;
  logic [7:0] vbyte;
  logic       v3f, p3f;

  int         n_chk = 0;
  int         n_err = 0;
  logic [7:0] r_b [5];
  logic       r_v3f, r_p3f;

  always #(CLK_P/2) clk = ~clk;

  vt_ptr_gen dut_i (
    .clk_i(clk), .rst_ni(rst_n), .vt2_i(vt2), .byte_sync_i(bs), .ais_i(ais),
    .inc_req_i(inc_r), .dec_req_i(dec_r), .ndf_req_i(ndf_r), .ptr_req_i(preq),
    .oh_dflt_i(OH), .stuff_dflt_i(ST), .v_stb_i(stb), .v_sel_i(sel),
    .vbyte_o(vbyte), .v3_data_o(v3f), .p3_stuff_o(p3f)
  );

  function automatic logic [15:0] wd(logic [3:0] nf, logic v2, logic [9:0] p, logic [9:0] m);
    return {nf, (v2 ? 2'b10 : 2'b11), p ^ m};
  endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one superframe: V1, V2, V3, byte after V3, V4; optional inc raised with V1
  task automatic sf(input logic co_inc);
    for (int s = 0; s < 5; s++) begin
      @(negedge clk);
      stb   = 1'b1;
      sel   = (s == 0) ? 3'd0 : (s == 1) ? 3'd1 : (s == 2) ? 3'd2 : (s == 3) ? 3'd4 : 3'd3;
      inc_r = (s == 0) && co_inc;
      #1;
      r_b[s] = vbyte;
      if (s == 2) r_v3f = v3f;
      if (s == 3) r_p3f = p3f;
    end
    @(negedge clk);
    stb   = 1'b0;
    inc_r = 1'b0;
  endtask

  task automatic idle(input int k);
    for (int i = 0; i < k; i++) sf(1'b0);
  endtask

  task automatic pulse(input logic i, input logic d, input logic nf, input logic [9:0] v);
    @(negedge clk);
    inc_r = i; dec_r = d; ndf_r = nf; preq = v;
    @(negedge clk);
    inc_r = 1'b0; dec_r = 1'b0; ndf_r = 1'b0;
  endtask

  task automatic chk_sf(input string tag, input logic [15:0] w, input logic [7:0] b3,
                        input logic [7:0] bp, input logic [7:0] b4, input logic f3, input logic fp);
    chk({tag, " word"}, {r_b[0], r_b[1]}, w);
    chk({tag, " V3"}, {8'h00, r_b[2]}, {8'h00, b3});
    chk({tag, " P3"}, {8'h00, r_b[3]}, {8'h00, bp});
    chk({tag, " V4"}, {8'h00, r_b[4]}, {8'h00, b4});
    chk({tag, " flags"}, {14'h0, r_v3f, r_p3f}, {14'h0, f3, fp});
  endtask

  task automatic t_reset;
    @(negedge clk); #1;
    chk("R12 idle after reset", {5'h0, v3f, p3f, 1'b0, vbyte}, 16'h0);
    stb = 1'b1; sel = 3'd6; #1;
    chk("R12 bad slot code", {5'h0, v3f, p3f, 1'b0, vbyte}, 16'h0);
    @(negedge clk); stb = 1'b0;
  endtask

  task automatic t_fixed;
    vt2 = 1'b0; bs = 1'b0;
    pulse(1'b1, 1'b0, 1'b1, 10'd20);
    sf(1'b0); chk_sf("R1 R2 R4 fixed vt15", wd(4'b0110, 1'b0, 10'd78, '0), OH, 8'h00, OH, 1'b0, 1'b0);
    pulse(1'b0, 1'b1, 1'b0, 10'd0);
    sf(1'b0); chk_sf("R1 fixed vt15 dec ignored", wd(4'b0110, 1'b0, 10'd78, '0), OH, 8'h00, OH, 1'b0, 1'b0);
    vt2 = 1'b1;
    sf(1'b0); chk_sf("R1 R2 R4 fixed vt2", wd(4'b0110, 1'b1, 10'd105, '0), OH, 8'h00, OH, 1'b0, 1'b0);
  endtask

  task automatic t_ais;
    ais = 1'b1; bs = 1'b1; vt2 = 1'b1;
    pulse(1'b1, 1'b0, 1'b0, 10'd0);
    sf(1'b0); chk_sf("R3 ais floating", 16'hFFFF, 8'hFF, 8'h00, 8'hFF, 1'b0, 1'b0);
    bs = 1'b0;
    sf(1'b0); chk_sf("R3 ais fixed", 16'hFFFF, 8'hFF, 8'h00, 8'hFF, 1'b0, 1'b0);
    ais = 1'b0; bs = 1'b1;
  endtask

  task automatic t_ndf;
    pulse(1'b0, 1'b0, 1'b1, 10'd50);
    sf(1'b0); chk_sf("R5 R11 ndf load", wd(4'b1001, 1'b1, 10'd50, '0), OH, 8'h00, OH, 1'b0, 1'b0);
    sf(1'b0); chk_sf("R5 R11 after ndf", wd(4'b0110, 1'b1, 10'd50, '0), OH, 8'h00, OH, 1'b0, 1'b0);
    pulse(1'b0, 1'b0, 1'b1, 10'd200);
    sf(1'b0); chk_sf("R5 out of range ignored", wd(4'b0110, 1'b1, 10'd50, '0), OH, 8'h00, OH, 1'b0, 1'b0);
    idle(3);
  endtask

  task automatic t_just_hold;
    pulse(1'b1, 1'b0, 1'b0, 10'd0);
    sf(1'b0); chk_sf("R6 inc frame", wd(4'b0110, 1'b1, 10'd50, IM), ST, ST, OH, 1'b0, 1'b1);
    pulse(1'b1, 1'b0, 1'b0, 10'd0);
    sf(1'b0); chk_sf("R9 R6 inc in hold discarded", wd(4'b0110, 1'b1, 10'd51, '0), OH, 8'h00, OH, 1'b0, 1'b0);
    idle(2);
    pulse(1'b0, 1'b1, 1'b0, 10'd0);
    sf(1'b0); chk_sf("R7 R9 dec at fourth frame", wd(4'b0110, 1'b1, 10'd51, DM), 8'h00, 8'h00, OH, 1'b1, 1'b0);
    sf(1'b0); chk_sf("R7 after dec", wd(4'b0110, 1'b1, 10'd50, '0), OH, 8'h00, OH, 1'b0, 1'b0);
    idle(2);
  endtask

  task automatic t_wrap;
    pulse(1'b0, 1'b0, 1'b1, 10'd139);
    sf(1'b0); idle(3);
    pulse(1'b1, 1'b0, 1'b0, 10'd0);
    sf(1'b0); chk_sf("R8 vt2 inc wrap", wd(4'b1001, 1'b1, 10'd0, '0), OH, 8'h00, OH, 1'b0, 1'b0);
    sf(1'b0); chk_sf("R8 after inc wrap", wd(4'b0110, 1'b1, 10'd0, '0), OH, 8'h00, OH, 1'b0, 1'b0);
    idle(2);
    pulse(1'b0, 1'b1, 1'b0, 10'd0);
    sf(1'b0); chk_sf("R8 vt2 dec wrap", wd(4'b1001, 1'b1, 10'd139, '0), OH, 8'h00, OH, 1'b0, 1'b0);
    idle(3);
    vt2 = 1'b0;
    pulse(1'b0, 1'b0, 1'b1, 10'd103);
    sf(1'b0); idle(3);
    pulse(1'b1, 1'b0, 1'b0, 10'd0);
    sf(1'b0); chk_sf("R8 vt15 inc wrap", wd(4'b1001, 1'b0, 10'd0, '0), OH, 8'h00, OH, 1'b0, 1'b0);
    idle(3);
  endtask

  task automatic t_prio_timing;
    pulse(1'b1, 1'b1, 1'b0, 10'd0);
    sf(1'b0); chk_sf("R10 inc over dec", wd(4'b0110, 1'b0, 10'd0, IM), ST, ST, OH, 1'b0, 1'b1);
    sf(1'b0); chk_sf("R6 vt15 after inc", wd(4'b0110, 1'b0, 10'd1, '0), OH, 8'h00, OH, 1'b0, 1'b0);
    idle(2);
    pulse(1'b1, 1'b0, 1'b1, 10'd60);
    sf(1'b0); chk_sf("R10 ndf over inc", wd(4'b1001, 1'b0, 10'd60, '0), OH, 8'h00, OH, 1'b0, 1'b0);
    idle(3);
    sf(1'b1); chk_sf("R10 inc with V1 not this frame", wd(4'b0110, 1'b0, 10'd60, '0), OH, 8'h00, OH, 1'b0, 1'b0);
    sf(1'b0); chk_sf("R10 inc with V1 next frame", wd(4'b0110, 1'b0, 10'd60, IM), ST, ST, OH, 1'b0, 1'b1);
    #1;
    chk("R12 idle after frame", {5'h0, v3f, p3f, 1'b0, vbyte}, 16'h0);
  endtask

  initial begin
    #(CLK_P * 100000);
    n_chk++; n_err++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_fixed();
    t_ais();
    t_ndf();
    t_just_hold();
    t_wrap();
    t_prio_timing();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule